// File: doc/BRIEF.md
# ADC Result Buffer Writer

This block receives the stream of accepted 16-bit conversion results and stores each one as a half-word in system memory. It uses a single-beat write port with a request/acknowledge handshake. Software describes a buffer by a start address and a length counted in samples, then issues a start pulse. The engine writes one result after another at rising addresses, two bytes apart. When the last slot is written, a sticky buffer-full flag is raised. Software clears that flag by writing a one to it.

In circular mode the engine returns to the start address after the last slot and keeps going. A one-slot buffer therefore always holds the latest result. In one-shot mode the engine goes idle after the last slot and drops later results until it is started again. The engine only sees the result stream, so a change in the converter's settings never stops it, and results from the old and new settings land in the buffer in arrival order. If the memory port is stalled when a new result arrives, the newer result takes the place of the one still waiting, and an overrun flag is raised.

Top module: `adc_dma_writer`

## Requirements
- R1: After reset, mem_req_o, busy_o, full_o and overrun_o are all 0.
- R2: A start pulse with a nonzero length makes busy_o 1 on the next cycle. Start address, length and the circular bit are captured at that pulse, and later changes on those inputs have no effect until the next start.
- R3: Result k of a pass (k counted from 0) is written to address (start address with bit 0 forced to 0) + 2k, with the result as write data. Results reach memory in arrival order.
- R4: When the last slot of the buffer is written, full_o becomes 1 one cycle after that write. A one on full_clr_i clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: In circular mode (wrap_i=1 at start), the slot after the last one is the start address again, and busy_o stays 1. With a length of 1, every result goes to the start address.
- R6: In one-shot mode (wrap_i=0 at start), busy_o drops one cycle after the last write. Results that arrive while the engine is idle are never written.
- R7: A stop pulse clears busy_o and drops any waiting write on the next cycle. A stop has priority over a start given in the same cycle, so the engine stays idle.
- R8: While mem_req_o=1 and mem_ack_i=0, mem_addr_o holds its value. If a new result arrives in that state, it replaces the waiting data at the same address and overrun_o becomes 1. A start or a stop clears overrun_o.
- R9: A start pulse with a length of 0 leaves the engine idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | One-cycle strobe: a result is present |
| smp_data_i | input | DW | Conversion result (signed, 16-bit default) |
| buf_base_i | input | AW | Buffer start byte address; bit 0 is ignored |
| buf_len_i | input | LW | Buffer length in samples |
| wrap_i | input | 1 | Circular mode select, captured at start |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse, takes priority over start |
| full_clr_i | input | 1 | Write-one-to-clear for full_o |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | AW | Write byte address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Write accepted in this cycle |
| busy_o | output | 1 | Engine is running |
| full_o | output | 1 | Sticky buffer-full flag |
| overrun_o | output | 1 | A waiting result was replaced by a newer one |

## Verification
The bench builds the block with AW=12 and LW=3. A narrow length field keeps every buffer short, so each test reaches the wrap point, the end of a one-shot pass and the full flag within a few results. The 12-bit address lets an odd start address show that bit 0 is dropped. DW stays at 16, so the stored values are the real signed results, including negative ones.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} dma_st_e;
endpackage

// File: rtl/dma_slot.sv
module dma_slot #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o,
  output logic          ovr_o
);
  logic stall;
  assign stall = vld_o && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      ovr_o  <= 1'b0;
    end else if (flush_i) begin
      vld_o <= 1'b0;
      ovr_o <= 1'b0;
    end else if (push_i) begin
      vld_o  <= 1'b1;
      data_o <= data_i;
      if (stall) ovr_o <= 1'b1;
    end else if (vld_o && ack_i) begin
      vld_o <= 1'b0;
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && !flush_i) |=> vld_o); // R8
  AST_OVR_ON_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall && push_i && !flush_i) |=> ovr_o); // R8
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= {base_i[AW-1:1], 1'b0};
      len_q  <= len_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q <= last_o ? '0 : idx_q + LW'(1);
    end
  end

  assign last_o = (idx_q == len_q - LW'(1));
  assign addr_o = base_q + AW'({idx_q, 1'b0});

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && last_o) |=> (addr_o == base_q)); // R5
endmodule

// File: rtl/adc_dma_writer.sv
module adc_dma_writer
  import adc_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic [AW-1:0] buf_base_i,
  input  logic [LW-1:0] buf_len_i,
  input  logic          wrap_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          full_clr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          full_o,
  output logic          overrun_o
);
  dma_st_e st_q;
  logic    wrap_q, load, wr_fire, last, done, accept;

  assign load    = start_i && !stop_i && (buf_len_i != '0);
  assign wr_fire = mem_req_o && mem_ack_i;
  assign done    = wr_fire && last;
  assign accept  = (st_q == ST_RUN) && smp_valid_i && !(done && !wrap_q)
                   && !stop_i && !load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wrap_q <= 1'b0;
      full_o <= 1'b0;
    end else begin
      if (stop_i)                st_q <= ST_IDLE;
      else if (load)             st_q <= ST_RUN;
      else if (done && !wrap_q)  st_q <= ST_IDLE;
      if (load) wrap_q <= wrap_i;
      if (done)            full_o <= 1'b1;
      else if (full_clr_i) full_o <= 1'b0;
    end
  end

  assign busy_o = (st_q == ST_RUN);

  dma_ptr #(.AW(AW), .LW(LW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (buf_base_i),
    .len_i  (buf_len_i),
    .step_i (wr_fire && !stop_i),
    .addr_o (mem_addr_o),
    .last_o (last)
  );

  dma_slot #(.DW(DW)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (stop_i || start_i),
    .push_i  (accept),
    .data_i  (smp_data_i),
    .ack_i   (mem_ack_i),
    .vld_o   (mem_req_o),
    .data_o  (mem_wdata_o),
    .ovr_o   (overrun_o)
  );

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && !mem_req_o)); // R7
  AST_FULL_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> full_o); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wrap_q && !start_i) |=> !busy_o); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !stop_i && !start_i) |=> $stable(mem_addr_o)); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !mem_req_o); // R6
endmodule

// File: tb/sim_adc_dma_writer.sv
module sim_adc_dma_writer;
  localparam int AW = 12, LW = 3, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, wrap = 1'b0, start = 1'b0, stop = 1'b0, fclr = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] len = '0;
  logic ack = 1'b1;
  logic req, busy, full, ovr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  int checks = 0, errors = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [AW-1:0] m_base;
  int m_len, m_idx;
  logic m_run, m_wrap;

  always #5 clk = ~clk;

  adc_dma_writer #(.AW(AW), .LW(LW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .buf_base_i(base), .buf_len_i(len), .wrap_i(wrap), .start_i(start), .stop_i(stop),
    .full_clr_i(fclr), .mem_req_o(req), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .busy_o(busy), .full_o(full), .overrun_o(ovr));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // monitor: a write commits at the next posedge when req && ack
  always @(negedge clk) begin
    if (rst_n && req && ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R6: actual write %0h<=%0h expected none", addr, wdata);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        if ({addr, wdata} !== e) begin
          errors++;
          $display("FAIL R3: actual %0h<=%0h expected %0h<=%0h",
                   addr, wdata, e[AW+DW-1:DW], e[DW-1:0]);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [AW-1:0] b, input int l, input logic w);
    @(posedge clk); #1;
    base = b; len = LW'(l); wrap = w; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    m_base = {b[AW-1:1], 1'b0}; m_len = l; m_idx = 0; m_run = (l != 0); m_wrap = w;
  endtask

  task automatic raw_smp(input logic [DW-1:0] d);
    @(posedge clk); #1;
    smp_valid = 1'b1; smp_data = d;
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  // driver: pushes expected item from the bench model, then drives
  task automatic send(input logic [DW-1:0] d);
    if (m_run) begin
      exp_q.push_back({m_base + AW'(2 * m_idx), d});
      m_idx++;
      if (m_idx == m_len) begin
        m_idx = 0;
        if (!m_wrap) m_run = 1'b0;
      end
    end
    raw_smp(d);
    tick(1);
  endtask

  initial begin
    tick(2);
    chk("R1 req", req, 0); chk("R1 busy", busy, 0);
    chk("R1 full", full, 0); chk("R1 ovr", ovr, 0);
    rst_n = 1'b1;
    tick(1);

    // one-shot, odd base, len 4
    do_load(12'h101, 4, 1'b0);
    chk("R2 busy", busy, 1);
    base = 12'h700; len = 3'd1; wrap = 1'b1; // must be ignored while running
    send(16'h1111); send(16'h8002); send(16'h0003);
    chk("R4 not full yet", full, 0);
    send(16'hfffc);
    tick(1);
    chk("R4 full", full, 1);
    chk("R6 idle", busy, 0);
    send(16'h5555); // ignored
    tick(3);
    chk("R6 no write", exp_q.size(), 0);
    @(posedge clk); #1; fclr = 1'b1; @(posedge clk); #1; fclr = 1'b0;
    chk("R4 cleared", full, 0);

    // circular, len 3
    do_load(12'h200, 3, 1'b1);
    for (int i = 0; i < 7; i++) send(16'(16'h20 + i));
    tick(2);
    chk("R5 busy", busy, 1);
    chk("R5 full", full, 1);
    @(posedge clk); #1; fclr = 1'b1; @(posedge clk); #1; fclr = 1'b0;

    // circular single slot
    do_load(12'h300, 1, 1'b1);
    send(16'h0aaa); send(16'h0bbb); send(16'h0ccc);
    tick(2);
    chk("R5 len1 busy", busy, 1);
    chk("R5 len1 full", full, 1);

    // overrun while stalled
    do_load(12'h400, 4, 1'b1);
    chk("R8 ovr cleared by start", ovr, 0);
    ack = 1'b0;
    raw_smp(16'hdead);
    chk("R8 req", req, 1);
    chk("R8 addr", addr, 12'h400);
    send(16'hbeef);
    chk("R8 addr held", addr, 12'h400);
    chk("R8 ovr", ovr, 1);
    ack = 1'b1;
    tick(3);
    chk("R8 drained", exp_q.size(), 0);

    // stop mid-run
    send(16'h0077);
    stop = 1'b1; tick(1); stop = 1'b0;
    chk("R7 stop busy", busy, 0);
    chk("R7 stop ovr", ovr, 0);
    m_run = 1'b0;
    raw_smp(16'h0099);
    // stop and start together
    @(posedge clk); #1; stop = 1'b1; start = 1'b1; len = 3'd2;
    @(posedge clk); #1; stop = 1'b0; start = 1'b0;
    chk("R7 stop wins", busy, 0);
    raw_smp(16'h0088);
    tick(3);
    chk("R7 no write", req, 0);

    // zero length
    do_load(12'h500, 0, 1'b1);
    chk("R9 idle", busy, 0);
    raw_smp(16'h0066);
    tick(3);
    chk("R9 queue", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule